// File: doc/BRIEF.md
# Dual-Master Downstream Channel Selector

This block decides which of two upstream serial-bus masters, if either, is joined to a single shared downstream bus. Each master owns a private control register. An upstream slave decoder writes that register through a port that has already been decoded. The port carries the index of the master that issued the write, and the write arrives on the acknowledge clock of the data byte. Each master can also read back its own bits, with the other master's ownership and enable bits folded in as read-only fields.

Register writes never move the downstream connection on their own. A pending change is applied only when a STOP condition is reported on the bus of the master that wrote last. At that point the block evaluates both registers. It breaks the old connection and raises a one-cycle bus-lost event for a master that was dropped. After at least one cycle with both channels open, it closes the new channel. If the writer asked for bus recovery, the block first triggers an external recovery sequencer and holds the channels open until that sequencer reports done. A parameter picks the reset state: either channel 0 connected, or nothing connected.

Top module: `dual_master_link_sel`

## Requirements
- R1: Reset state with BOOT_CH0_ON=1: readback 0x04 for master 0, readback 0x0A for master 1, conn_en=2'b01. Reset state with BOOT_CH0_ON=0: readback 0x00 and 0x02, conn_en=2'b00. lost_pulse and rcv_start are 0 in both cases.
- R2: Readback for master i is {test_other(7), test_self(6), 0(5), recover_req(4), other_on(3), on(2), other_own(1), own(0)}. Bit 3 is the other master's bit 2. Bit 1 is the other master's bit 0 for master 0, and its inverse for master 1. Written bits 5, 3 and 1 are ignored.
- R3: The downstream connection is on exactly when the two stored on bits differ. When it is off, the ownership bits have no effect.
- R4: When the connection is on, the channel selected is the XOR of the two stored own bits: 0 selects channel 0 and 1 selects channel 1. A master therefore owns the bus when its bits 1 and 0 read equal.
- R5: A pending change is applied only when stop_det is high for the master that wrote last. A STOP from the other master changes nothing.
- R6: When both masters write, the register contents at the last writer's STOP decide the outcome, and only that writer's STOP applies it.
- R7: When a connected channel is opened by a switch, lost_pulse for that master is high for exactly one cycle, on the cycle the channel opens.
- R8: conn_en never has both bits set. On a switch, conn_en drops to 2'b00 in the cycle after the qualifying STOP is sampled. The new channel closes one cycle later.
- R9: If the last writer's recover_req bit is 1 and a channel is to be closed, rcv_start pulses for one cycle in the cycle after the disconnect. conn_en stays 2'b00 until rcv_done is sampled high, and the channel closes on that edge.
- R10: A qualifying STOP with no pending write, or with a target equal to the present connection, leaves conn_en unchanged and raises no lost_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Decoded control-register write strobe (acknowledge clock) |
| wr_master | input | 1 | Index of the master issuing the write |
| wr_data | input | 8 | Byte written to that master's control register |
| stop_det | input | 2 | One-cycle STOP indication per upstream bus |
| rcv_done | input | 1 | Recovery sequencer finished |
| conn_en | output | 2 | Connect enable for channel 0 (bit 0) and channel 1 (bit 1) |
| lost_pulse | output | 2 | One-cycle bus-lost event per master |
| rcv_start | output | 1 | One-cycle start request to the recovery sequencer |
| rd_data_m0 | output | 8 | Control readback seen by master 0 |
| rd_data_m1 | output | 8 | Control readback seen by master 1 |

## Verification
A stored bit that is wrong shows up on the readback ports in the cycle after the write. A wrong mirror or inversion makes the two masters' views disagree with each other. A wrong pending flag or last-writer index shows up only at the next STOP. The symptom is either a connection that moves on the wrong master's STOP, or one that fails to move. A fault in the switch sequencer shows within two cycles of the STOP: an overlap of both enables, a missing open gap, a lost event on the wrong master, or a channel that closes before recovery completes.

// File: rtl/dmls_pkg.sv
package dmls_pkg;
    localparam int NUM_M  = 2;
    localparam int REG_W  = 8;
    // field positions of the control byte (decoded by upstream masters)
    localparam int B_OWN      = 0;
    localparam int B_OTH_OWN  = 1;
    localparam int B_ON       = 2;
    localparam int B_OTH_ON   = 3;
    localparam int B_RECOVER  = 4;
    localparam int B_TEST     = 6;
    localparam int B_TEST_OTH = 7;

    typedef struct packed {
        logic test_oth;
        logic test_self;
        logic recover;
        logic on;
        logic own;
    } ctl_t;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_GAP  = 2'd1,
        SW_RCV  = 2'd2
    } sw_state_e;
endpackage

// File: rtl/dmls_ctl_regs.sv
module dmls_ctl_regs
    import dmls_pkg::*;
#(
    parameter bit BOOT_CH0_ON = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_master,
    input  logic [REG_W-1:0] wr_data,
    output logic [NUM_M-1:0] own_o,
    output logic [NUM_M-1:0] on_o,
    output logic [NUM_M-1:0] recover_o,
    output logic [REG_W-1:0] rd_o [NUM_M]
);
    localparam ctl_t CTL_ZERO = '{default: 1'b0};

    ctl_t [NUM_M-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d[wr_master].test_oth  = wr_data[B_TEST_OTH];
            bank_d[wr_master].test_self = wr_data[B_TEST];
            bank_d[wr_master].recover   = wr_data[B_RECOVER];
            bank_d[wr_master].on        = wr_data[B_ON];
            bank_d[wr_master].own       = wr_data[B_OWN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q       <= {NUM_M{CTL_ZERO}};
            bank_q[0].on <= BOOT_CH0_ON;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar gi = 0; gi < NUM_M; gi++) begin : g_view
        localparam int OTH = NUM_M - 1 - gi;
        localparam bit INV = (gi != 0);
        assign own_o[gi]     = bank_q[gi].own;
        assign on_o[gi]      = bank_q[gi].on;
        assign recover_o[gi] = bank_q[gi].recover;
        always_comb begin
            rd_o[gi]             = '0;
            rd_o[gi][B_TEST_OTH] = bank_q[gi].test_oth;
            rd_o[gi][B_TEST]     = bank_q[gi].test_self;
            rd_o[gi][B_RECOVER]  = bank_q[gi].recover;
            rd_o[gi][B_OTH_ON]   = bank_q[OTH].on;
            rd_o[gi][B_ON]       = bank_q[gi].on;
            rd_o[gi][B_OTH_OWN]  = bank_q[OTH].own ^ INV;
            rd_o[gi][B_OWN]      = bank_q[gi].own;
        end
    end
endmodule

// File: rtl/dmls_target.sv
module dmls_target
    import dmls_pkg::*;
(
    input  logic [NUM_M-1:0] own_i,
    input  logic [NUM_M-1:0] on_i,
    output logic             tgt_on_o,
    output logic             tgt_ch_o
);
    always_comb begin
        tgt_on_o = ^on_i;
        tgt_ch_o = tgt_on_o ? (^own_i) : 1'b0;
    end
endmodule

// File: rtl/dmls_switch_ctl.sv
module dmls_switch_ctl
    import dmls_pkg::*;
#(
    parameter bit BOOT_CH0_ON = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_master,
    input  logic [NUM_M-1:0] stop_det,
    input  logic             rcv_done,
    input  logic             tgt_on,
    input  logic             tgt_ch,
    input  logic [NUM_M-1:0] recover,
    output logic [NUM_M-1:0] conn_en,
    output logic [NUM_M-1:0] lost_pulse,
    output logic             rcv_start
);
    typedef struct packed {
        sw_state_e        st;
        logic [NUM_M-1:0] conn;
        logic [NUM_M-1:0] lost;
        logic             rcv_go;
        logic             cur_on;
        logic             cur_ch;
        logic             pend;
        logic             last_wr;
        logic             use_rcv;
    } sw_t;

    localparam sw_t SW_RST = '{
        st:      SW_IDLE,
        conn:    (BOOT_CH0_ON ? 2'b01 : 2'b00),
        lost:    '0,
        rcv_go:  1'b0,
        cur_on:  BOOT_CH0_ON,
        cur_ch:  1'b0,
        pend:    1'b0,
        last_wr: 1'b0,
        use_rcv: 1'b0
    };

    sw_t q, d;
    logic fire;
    logic differs;

    always_comb begin
        d        = q;
        d.lost   = '0;
        d.rcv_go = 1'b0;
        fire     = q.pend && stop_det[q.last_wr];
        differs  = (tgt_on != q.cur_on) || (tgt_on && (tgt_ch != q.cur_ch));
        unique case (q.st)
            SW_IDLE: begin
                if (fire) begin
                    d.pend = 1'b0;
                    if (differs) begin
                        if (q.cur_on) d.lost[q.cur_ch] = 1'b1;
                        d.conn    = '0;
                        d.cur_on  = tgt_on;
                        d.cur_ch  = tgt_ch;
                        d.use_rcv = recover[q.last_wr];
                        if (tgt_on) d.st = SW_GAP;
                    end
                end
            end
            SW_GAP: begin
                if (q.use_rcv) begin
                    d.rcv_go = 1'b1;
                    d.st     = SW_RCV;
                end else begin
                    d.conn[q.cur_ch] = 1'b1;
                    d.st             = SW_IDLE;
                end
            end
            SW_RCV: begin
                if (rcv_done) begin
                    d.conn[q.cur_ch] = 1'b1;
                    d.st             = SW_IDLE;
                end
            end
            default: d.st = SW_IDLE;
        endcase
        if (wr_en) begin
            d.pend    = 1'b1;
            d.last_wr = wr_master;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SW_RST;
        else        q <= d;
    end

    assign conn_en    = q.conn;
    assign lost_pulse = q.lost;
    assign rcv_start  = q.rcv_go;
endmodule

// File: rtl/dual_master_link_sel.sv
module dual_master_link_sel
    import dmls_pkg::*;
#(
    parameter bit BOOT_CH0_ON = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_master,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NUM_M-1:0] stop_det,
    input  logic             rcv_done,
    output logic [NUM_M-1:0] conn_en,
    output logic [NUM_M-1:0] lost_pulse,
    output logic             rcv_start,
    output logic [REG_W-1:0] rd_data_m0,
    output logic [REG_W-1:0] rd_data_m1
);
    logic [NUM_M-1:0] own_w, on_w, recover_w;
    logic [REG_W-1:0] rd_w [NUM_M];
    logic             tgt_on_w, tgt_ch_w;

    dmls_ctl_regs #(.BOOT_CH0_ON(BOOT_CH0_ON)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_master (wr_master),
        .wr_data   (wr_data),
        .own_o     (own_w),
        .on_o      (on_w),
        .recover_o (recover_w),
        .rd_o      (rd_w)
    );

    dmls_target target_i (
        .own_i    (own_w),
        .on_i     (on_w),
        .tgt_on_o (tgt_on_w),
        .tgt_ch_o (tgt_ch_w)
    );

    dmls_switch_ctl #(.BOOT_CH0_ON(BOOT_CH0_ON)) sw_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_master  (wr_master),
        .stop_det   (stop_det),
        .rcv_done   (rcv_done),
        .tgt_on     (tgt_on_w),
        .tgt_ch     (tgt_ch_w),
        .recover    (recover_w),
        .conn_en    (conn_en),
        .lost_pulse (lost_pulse),
        .rcv_start  (rcv_start)
    );

    assign rd_data_m0 = rd_w[0];
    assign rd_data_m1 = rd_w[1];
endmodule

// File: rtl/dmls_sva.sv
module dmls_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] stop_det,
    input logic [1:0] conn_en,
    input logic [1:0] lost_pulse,
    input logic       rcv_start
);
    AST_CONN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(conn_en[0] && conn_en[1])); // R8

    AST_GAP_FROM_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_en == 2'b01) |=> (conn_en != 2'b10)); // R8

    AST_GAP_FROM_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_en == 2'b10) |=> (conn_en != 2'b01)); // R8

    AST_LOST_CH0_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse[0] |-> (!conn_en[0] && $past(conn_en[0]))); // R7

    AST_LOST_CH1_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse[1] |-> (!conn_en[1] && $past(conn_en[1]))); // R7

    AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lost_pulse)); // R7

    AST_OPEN_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(conn_en) & ~conn_en) != 2'b00) |-> ($past(stop_det) != 2'b00)); // R5

    AST_RCV_CHANNELS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_start |-> (conn_en == 2'b00)); // R9
endmodule

bind dual_master_link_sel dmls_sva sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_det   (stop_det),
    .conn_en    (conn_en),
    .lost_pulse (lost_pulse),
    .rcv_start  (rcv_start)
);

// File: tb/dual_master_link_sel_tb_top.sv
module dual_master_link_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_master = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] stop_det = '0;
    logic       rcv_done = 1'b0;
    logic [1:0] conn_en, lost_pulse, conn_b, lost_b;
    logic       rcv_start, rcv_b;
    logic [7:0] rd0, rd1, rd0_b, rd1_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dual_master_link_sel #(.BOOT_CH0_ON(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_master(wr_master),
        .wr_data(wr_data), .stop_det(stop_det), .rcv_done(rcv_done),
        .conn_en(conn_en), .lost_pulse(lost_pulse), .rcv_start(rcv_start),
        .rd_data_m0(rd0), .rd_data_m1(rd1)
    );

    dual_master_link_sel #(.BOOT_CH0_ON(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_master(wr_master),
        .wr_data(wr_data), .stop_det(stop_det), .rcv_done(rcv_done),
        .conn_en(conn_b), .lost_pulse(lost_b), .rcv_start(rcv_b),
        .rd_data_m0(rd0_b), .rd_data_m1(rd1_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic m, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_master = m; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // returns at the negedge right after the edge that sampled the STOP
    task automatic do_stop(input int m);
        @(negedge clk);
        stop_det[m] = 1'b1;
        @(negedge clk);
        stop_det = '0;
    endtask

    task automatic t_reset;
        check("R1 m0 readback", rd0, 8'h04);
        check("R1 m1 readback", rd1, 8'h0A);
        check("R1 conn", {6'b0, conn_en}, 8'h01);
        check("R1 lost/rcv", {5'b0, rcv_start, lost_pulse}, 8'h00);
        check("R1 alt m0 readback", rd0_b, 8'h00);
        check("R1 alt m1 readback", rd1_b, 8'h02);
        check("R1 alt conn", {6'b0, conn_b}, 8'h00);
    endtask

    task automatic t_readback;
        do_write(1'b0, 8'hFF);
        check("R2 m0 view after 0xFF", rd0, 8'hD5);
        check("R2 m1 mirror", rd1, 8'h08);
        do_write(1'b0, 8'h04);
        check("R2 m0 restored", rd0, 8'h04);
    endtask

    task automatic t_other_stop;
        do_write(1'b1, 8'h01);
        do_stop(0);
        check("R5 foreign STOP conn", {6'b0, conn_en}, 8'h01);
        check("R5 foreign STOP lost", {6'b0, lost_pulse}, 8'h00);
        @(negedge clk);
        check("R5 foreign STOP conn later", {6'b0, conn_en}, 8'h01);
    endtask

    task automatic t_switch;
        do_stop(1);
        check("R8 break cycle", {6'b0, conn_en}, 8'h00);
        check("R7 lost to m0", {6'b0, lost_pulse}, 8'h01);
        @(negedge clk);
        check("R4 ch1 closed", {6'b0, conn_en}, 8'h02);
        check("R7 lost one cycle", {6'b0, lost_pulse}, 8'h00);
    endtask

    task automatic t_busoff;
        do_write(1'b1, 8'h05);
        do_stop(1);
        check("R3 off conn", {6'b0, conn_en}, 8'h00);
        check("R7 lost to m1", {6'b0, lost_pulse}, 8'h02);
        check("R2 m0 view while off", rd0, 8'h0E);
        repeat (2) @(negedge clk);
        check("R3 stays off", {6'b0, conn_en}, 8'h00);
        do_write(1'b0, 8'h05);
        do_stop(0);
        @(negedge clk);
        check("R3 ownership ignored when off", {6'b0, conn_en}, 8'h00);
        check("R10 no lost when off", {6'b0, lost_pulse}, 8'h00);
    endtask

    task automatic t_connect;
        do_write(1'b0, 8'h01);
        do_stop(0);
        check("R8 open before close", {6'b0, conn_en}, 8'h00);
        @(negedge clk);
        check("R4 ch0 closed", {6'b0, conn_en}, 8'h01);
    endtask

    task automatic t_race;
        do_write(1'b0, 8'h00);
        do_write(1'b1, 8'h05);
        do_stop(0);
        @(negedge clk);
        check("R6 earlier writer STOP ignored", {6'b0, conn_en}, 8'h01);
        do_stop(1);
        check("R6 last writer STOP lost", {6'b0, lost_pulse}, 8'h01);
        @(negedge clk);
        check("R6 last writer wins", {6'b0, conn_en}, 8'h02);
        do_stop(1);
        @(negedge clk);
        check("R10 repeat STOP no change", {6'b0, conn_en}, 8'h02);
        check("R10 repeat STOP no lost", {6'b0, lost_pulse}, 8'h00);
    endtask

    task automatic t_recover;
        do_write(1'b0, 8'h11);
        check("R2 recover bit readback", rd0, 8'h1B);
        do_stop(0);
        check("R9 lost to m1", {6'b0, lost_pulse}, 8'h02);
        @(negedge clk);
        check("R9 start pulse", {7'b0, rcv_start}, 8'h01);
        check("R9 held open", {6'b0, conn_en}, 8'h00);
        repeat (5) @(negedge clk);
        check("R9 start one cycle", {7'b0, rcv_start}, 8'h00);
        check("R9 still open", {6'b0, conn_en}, 8'h00);
        rcv_done = 1'b1;
        @(negedge clk);
        rcv_done = 1'b0;
        check("R9 closes on done", {6'b0, conn_en}, 8'h01);
        do_stop(0);
        @(negedge clk);
        check("R10 no pending write", {7'b0, rcv_start}, 8'h00);
        check("R10 conn kept", {6'b0, conn_en}, 8'h01);
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_other_stop();
        t_switch();
        t_busoff();
        t_connect();
        t_race();
        t_recover();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule